// File: doc/BRIEF.md
# Spanning Tree Port Forwarding Gate

This block sits behind the address lookup of a five-port switch and makes the final per-packet forwarding and learning decision. Port 5 is the processor port; ports 1 to 4 each carry a three-bit spanning tree control setting (transmit enable, receive enable, learning disable) written through a small register write interface. For every packet the block receives the ingress port, the destination bitmap from lookup, a static-table hit flag with its override bit and a processor-tag flag, and produces the final egress mask, a drop flag and a source-address learn strobe.

A port with receive disabled only lets through frames that hit a static entry with the override bit set (for example bridge protocol frames), and those go to the processor port alone. Tagged frames from the processor may leave through ports whose transmit enable is cleared, which allows the processor to send protocol frames out of a listening port. The decision appears one clock after the input strobe.

Top module: `stp_fwd_gate`

## Requirements
- R1: After reset every port 1..4 holds transmit enable 0, receive enable 0, learning disable 1, so a packet from port 1 is dropped without learning and an untagged processor packet to port 1 is dropped.
- R2: A write with reg_we_i high updates port 1, 2, 3 or 4 when reg_addr_i is 18, 34, 50 or 66; data bit 2 is transmit enable, bit 1 receive enable, bit 0 learning disable. Writes to any other address change nothing.
- R3: out_valid_o is high exactly one clock after pkt_valid_i was high; in a cycle following no input strobe, egress_mask_o is zero and drop_o and learn_o are low.
- R4: With an ingress port set to transmit 1, receive 1, learning disable 0 and all destinations transmit-enabled, the egress mask equals the lookup mask minus the ingress bit and learn_o is high.
- R5: For untagged traffic, egress bits of ports 1..4 whose transmit enable is 0 are cleared; the port 5 bit is never cleared by this rule.
- R6: The ingress port bit is always cleared in the egress mask, tagged frames included.
- R7: When the ingress port (1..4) has receive enable 0, a packet with both static hit and override set leaves with the egress mask 5'b10000 (port 5 only); any other packet from that port is dropped.
- R8: learn_o is high for a valid packet if and only if the ingress port's learning disable bit is 0; port 5 ingress always learns.
- R9: A packet from port 5 with cpu_tag_i set ignores transmit enable of the destinations; cpu_tag_i on a packet from ports 1..4 has no effect.
- R10: drop_o is high with a valid decision exactly when the egress mask is zero.
- R11: A register write and a packet in the same cycle: the packet uses the setting before the write; the next packet uses the new one.
- R12: pkt_src_i encodes port 1..5 as 0..4 and egress mask bit i stands for port i+1; source codes 5..7 are dropped without learning.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| reg_we_i | input | 1 | Register write strobe |
| reg_addr_i | input | 8 | Register address |
| reg_wdata_i | input | 8 | Register write data |
| pkt_valid_i | input | 1 | Packet decision request |
| pkt_src_i | input | 3 | Ingress port code (0..4 = port 1..5) |
| pkt_dst_mask_i | input | 5 | Destination bitmap from lookup |
| static_hit_i | input | 1 | Static-table hit |
| static_override_i | input | 1 | Override bit of the static entry |
| cpu_tag_i | input | 1 | Frame carries processor tag |
| out_valid_o | output | 1 | Decision valid |
| egress_mask_o | output | 5 | Final egress bitmap |
| drop_o | output | 1 | Packet dropped |
| learn_o | output | 1 | Source-address learn strobe |

## Verification
A register write and a packet decision can fall in the same clock edge, and the packet must see the old port setting. The bench provokes this by raising reg_we_i and pkt_valid_i together, the write turning port 1 from forwarding to disabled while the packet comes from port 1. The first decision must still forward and learn, and a second packet right after must be dropped with no learn strobe.

// File: rtl/stp_gate_pkg.sv
package stp_gate_pkg;
  localparam int unsigned NUM_PORTS     = 5;
  localparam int unsigned NUM_STP_PORTS = NUM_PORTS - 1;
  localparam int unsigned CPU_IDX       = NUM_PORTS - 1;
  localparam int unsigned SRC_W         = $clog2(NUM_PORTS);
  localparam int unsigned ADDR_W        = 8;
  localparam int unsigned DATA_W        = 8;
  localparam int unsigned REG_BASE      = 18;
  localparam int unsigned REG_STRIDE    = 16;
  localparam int unsigned TX_BIT        = 2;
  localparam int unsigned RX_BIT        = 1;
  localparam int unsigned LD_BIT        = 0;

  typedef logic [NUM_PORTS-1:0]     port_mask_t;
  typedef logic [NUM_STP_PORTS-1:0] stp_vec_t;
endpackage

// File: rtl/stp_port_regs.sv
module stp_port_regs
  import stp_gate_pkg::*;
(
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              reg_we_i,
  input  logic [ADDR_W-1:0] reg_addr_i,
  input  logic [DATA_W-1:0] reg_wdata_i,
  output stp_vec_t          tx_en_o,
  output stp_vec_t          rx_en_o,
  output stp_vec_t          learn_dis_o
);
  stp_vec_t sel;

  for (genvar p = 0; p < NUM_STP_PORTS; p++) begin : g_port
    localparam logic [ADDR_W-1:0] PortAddr = ADDR_W'(REG_BASE + REG_STRIDE * p);
    assign sel[p] = reg_we_i && (reg_addr_i == PortAddr);

    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
        tx_en_o[p]     <= 1'b0;
        rx_en_o[p]     <= 1'b0;
        learn_dis_o[p] <= 1'b1;
      end else if (sel[p]) begin
        tx_en_o[p]     <= reg_wdata_i[TX_BIT];
        rx_en_o[p]     <= reg_wdata_i[RX_BIT];
        learn_dis_o[p] <= reg_wdata_i[LD_BIT];
      end
    end
  end

  logic wdata_unused;
  assign wdata_unused = ^reg_wdata_i[DATA_W-1:TX_BIT+1];

  // Writes outside the four decoded addresses leave every setting untouched.
  assert_decode_only_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(reg_we_i && (reg_addr_i == 8'd18 || reg_addr_i == 8'd34 ||
                   reg_addr_i == 8'd50 || reg_addr_i == 8'd66))
    |=> $stable({tx_en_o, rx_en_o, learn_dis_o}));
endmodule

// File: rtl/stp_decide.sv
module stp_decide
  import stp_gate_pkg::*;
(
  input  logic [SRC_W-1:0] src_i,
  input  port_mask_t       dst_mask_i,
  input  logic             static_hit_i,
  input  logic             static_override_i,
  input  logic             cpu_tag_i,
  input  stp_vec_t         tx_en_i,
  input  stp_vec_t         rx_en_i,
  input  stp_vec_t         learn_dis_i,
  output port_mask_t       mask_o,
  output logic             learn_o
);
  logic       src_ok, src_cpu, port_rx, port_ld;
  port_mask_t self_mask, tx_ok, cpu_bit;

  assign src_ok  = src_i < SRC_W'(NUM_PORTS);
  assign src_cpu = src_i == SRC_W'(CPU_IDX);
  assign tx_ok   = {1'b1, tx_en_i};
  assign cpu_bit = port_mask_t'(1) << CPU_IDX;

  always_comb begin
    self_mask = '0;
    for (int p = 0; p < NUM_PORTS; p++)
      if (src_i == SRC_W'(p)) self_mask[p] = 1'b1;
  end

  always_comb begin
    port_rx = src_cpu;
    port_ld = !src_cpu;
    for (int p = 0; p < NUM_STP_PORTS; p++)
      if (src_i == SRC_W'(p)) begin
        port_rx = rx_en_i[p];
        port_ld = learn_dis_i[p];
      end
  end

  always_comb begin
    if (!src_ok)
      mask_o = '0;
    else if (!port_rx)
      mask_o = (static_hit_i && static_override_i) ? cpu_bit : '0;
    else if (src_cpu && cpu_tag_i)
      mask_o = dst_mask_i & ~self_mask;
    else
      mask_o = dst_mask_i & tx_ok & ~self_mask;
  end

  assign learn_o = src_ok && !port_ld;
endmodule

// File: rtl/stp_fwd_gate.sv
module stp_fwd_gate
  import stp_gate_pkg::*;
(
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             reg_we_i,
  input  logic [7:0]       reg_addr_i,
  input  logic [7:0]       reg_wdata_i,
  input  logic             pkt_valid_i,
  input  logic [2:0]       pkt_src_i,
  input  logic [4:0]       pkt_dst_mask_i,
  input  logic             static_hit_i,
  input  logic             static_override_i,
  input  logic             cpu_tag_i,
  output logic             out_valid_o,
  output logic [4:0]       egress_mask_o,
  output logic             drop_o,
  output logic             learn_o
);
  stp_vec_t   tx_en, rx_en, learn_dis;
  port_mask_t dec_mask;
  logic       dec_learn;

  stp_port_regs i_regs (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .reg_we_i    (reg_we_i),
    .reg_addr_i  (reg_addr_i),
    .reg_wdata_i (reg_wdata_i),
    .tx_en_o     (tx_en),
    .rx_en_o     (rx_en),
    .learn_dis_o (learn_dis)
  );

  stp_decide i_decide (
    .src_i             (pkt_src_i),
    .dst_mask_i        (pkt_dst_mask_i),
    .static_hit_i      (static_hit_i),
    .static_override_i (static_override_i),
    .cpu_tag_i         (cpu_tag_i),
    .tx_en_i           (tx_en),
    .rx_en_i           (rx_en),
    .learn_dis_i       (learn_dis),
    .mask_o            (dec_mask),
    .learn_o           (dec_learn)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      out_valid_o   <= 1'b0;
      egress_mask_o <= '0;
      drop_o        <= 1'b0;
      learn_o       <= 1'b0;
    end else begin
      out_valid_o   <= pkt_valid_i;
      egress_mask_o <= pkt_valid_i ? dec_mask : '0;
      drop_o        <= pkt_valid_i && (dec_mask == '0);
      learn_o       <= pkt_valid_i && dec_learn;
    end
  end

  assert_one_cycle_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    pkt_valid_i |=> out_valid_o);

  assert_idle_quiet_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !pkt_valid_i |=> !out_valid_o && egress_mask_o == '0 && !learn_o && !drop_o);

  assert_no_hairpin_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (pkt_valid_i && pkt_src_i < 3'd5) |=> !egress_mask_o[$past(pkt_src_i)]);

  assert_rx_block_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (pkt_valid_i && pkt_src_i < 3'd4 && !rx_en[pkt_src_i[1:0]])
    |=> egress_mask_o[3:0] == 4'b0000);

  assert_learn_gate_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (pkt_valid_i && pkt_src_i < 3'd4 && learn_dis[pkt_src_i[1:0]]) |=> !learn_o);

  assert_tag_bypass_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (pkt_valid_i && pkt_src_i == 3'd4 && cpu_tag_i)
    |=> egress_mask_o == ($past(pkt_dst_mask_i) & 5'b01111));
endmodule

// File: tb/test_stp_fwd_gate.sv
`timescale 1ns/1ps
module test_stp_fwd_gate;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       we = 1'b0;
  logic [7:0] addr = '0, wdata = '0;
  logic       pv = 1'b0;
  logic [2:0] src = '0;
  logic [4:0] dst = '0;
  logic       hit = 1'b0, ovr = 1'b0, tag = 1'b0;
  logic       ov, drop, learn;
  logic [4:0] emask;

  int errors = 0;
  int checks = 0;
  logic [3:0] m_tx, m_rx, m_ld;

  always #10 clk = ~clk;

  stp_fwd_gate i_stp_fwd_gate (
    .clk_i(clk), .rst_ni(rst_n), .reg_we_i(we), .reg_addr_i(addr), .reg_wdata_i(wdata),
    .pkt_valid_i(pv), .pkt_src_i(src), .pkt_dst_mask_i(dst), .static_hit_i(hit),
    .static_override_i(ovr), .cpu_tag_i(tag), .out_valid_o(ov), .egress_mask_o(emask),
    .drop_o(drop), .learn_o(learn)
  );

  task automatic chk(input string req, input string what, input int act, input int exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s %s: actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  function automatic logic [4:0] model_mask(input logic [2:0] s, input logic [4:0] d,
                                            input logic h, input logic o, input logic t);
    logic [4:0] self;
    if (s > 3'd4) return 5'b0;
    self = 5'b1 << s;
    if (s < 3'd4 && !m_rx[s[1:0]]) return (h && o) ? 5'b10000 : 5'b0;
    if (s == 3'd4 && t) return d & ~self;
    return d & {1'b1, m_tx} & ~self;
  endfunction

  function automatic logic model_learn(input logic [2:0] s);
    if (s > 3'd4) return 1'b0;
    if (s == 3'd4) return 1'b1;
    return !m_ld[s[1:0]];
  endfunction

  task automatic model_write(input logic [7:0] a, input logic [7:0] d);
    for (int p = 0; p < 4; p++)
      if (a == 8'(18 + 16 * p)) begin
        m_tx[p] = d[2]; m_rx[p] = d[1]; m_ld[p] = d[0];
      end
  endtask

  task automatic wr(input logic [7:0] a, input logic [7:0] d);
    @(negedge clk);
    we = 1'b1; addr = a; wdata = d;
    @(negedge clk);
    we = 1'b0;
    model_write(a, d);
  endtask

  task automatic check_out(input string req, input logic [4:0] em, input logic el);
    chk(req, "valid", ov, 1);
    chk(req, "mask", emask, em);
    chk("R10", "drop", drop, em == 5'b0);
    chk(req, "learn", learn, el);
  endtask

  task automatic send(input string req, input logic [2:0] s, input logic [4:0] d,
                      input logic h, input logic o, input logic t);
    logic [4:0] em;
    logic el;
    em = model_mask(s, d, h, o, t);
    el = model_learn(s);
    @(negedge clk);
    pv = 1'b1; src = s; dst = d; hit = h; ovr = o; tag = t;
    @(negedge clk);
    pv = 1'b0; hit = 1'b0; ovr = 1'b0; tag = 1'b0;
    check_out(req, em, el);
  endtask

  task automatic t_reset;
    chk("R3", "reset valid", ov, 0);
    chk("R3", "reset mask", emask, 0);
    send("R1", 3'd0, 5'b10000, 1'b0, 1'b0, 1'b0);
    chk("R1", "port1 dropped", drop, 1);
    send("R1", 3'd4, 5'b00001, 1'b0, 1'b0, 1'b0);
    chk("R1", "cpu to port1 dropped", emask, 0);
    @(negedge clk);
    chk("R3", "idle valid", ov, 0);
    chk("R3", "idle learn", learn, 0);
  endtask

  task automatic t_forward;
    for (int p = 0; p < 4; p++) wr(8'(18 + 16 * p), 8'b110);
    send("R4", 3'd0, 5'b11111, 1'b0, 1'b0, 1'b0);
    chk("R4", "fwd mask", emask, 5'b11110);
    chk("R8", "fwd learn", learn, 1);
    send("R6", 3'd2, 5'b00100, 1'b0, 1'b0, 1'b0);
    chk("R6", "self only dropped", drop, 1);
  endtask

  task automatic t_tx_gate;
    wr(8'd34, 8'b010);
    send("R5", 3'd0, 5'b11111, 1'b0, 1'b0, 1'b0);
    chk("R5", "port2 cleared", emask, 5'b11100);
    send("R5", 3'd3, 5'b10010, 1'b0, 1'b0, 1'b0);
    chk("R5", "port5 kept", emask, 5'b10000);
    send("R5", 3'd4, 5'b01111, 1'b0, 1'b0, 1'b0);
  endtask

  task automatic t_rx_block;
    wr(8'd50, 8'b001);
    send("R7", 3'd2, 5'b00001, 1'b1, 1'b1, 1'b0);
    chk("R7", "override to cpu", emask, 5'b10000);
    chk("R8", "no learn disabled", learn, 0);
    send("R7", 3'd2, 5'b10001, 1'b1, 1'b0, 1'b0);
    chk("R7", "hit no override", drop, 1);
    send("R7", 3'd2, 5'b10001, 1'b0, 1'b1, 1'b0);
    chk("R7", "override no hit", drop, 1);
  endtask

  task automatic t_tag;
    send("R9", 3'd4, 5'b01111, 1'b0, 1'b0, 1'b1);
    chk("R9", "tag bypass", emask, 5'b01111);
    send("R6", 3'd4, 5'b11111, 1'b0, 1'b0, 1'b1);
    chk("R6", "tag self cleared", emask, 5'b01111);
    send("R9", 3'd0, 5'b01110, 1'b0, 1'b0, 1'b1);
    chk("R9", "tag ignored port1", emask, 5'b01000);
  endtask

  task automatic t_decode;
    wr(8'd19, 8'b110);
    send("R2", 3'd0, 5'b00010, 1'b0, 1'b0, 1'b0);
    chk("R2", "addr19 ignored", drop, 1);
    wr(8'd66, 8'b001);
    send("R2", 3'd3, 5'b00001, 1'b0, 1'b0, 1'b0);
    chk("R2", "addr66 disables port4", drop, 1);
    wr(8'd82, 8'b110);
    send("R2", 3'd3, 5'b00001, 1'b0, 1'b0, 1'b0);
    chk("R8", "addr82 ignored learn", learn, 0);
    wr(8'd66, 8'b111);
    send("R8", 3'd3, 5'b00001, 1'b0, 1'b0, 1'b0);
    chk("R8", "learn disabled forwarding", learn, 0);
    chk("R4", "port4 rx forwards", emask, 5'b00001);
  endtask

  task automatic t_same_cycle;
    logic [4:0] em;
    em = model_mask(3'd0, 5'b10000, 1'b0, 1'b0, 1'b0);
    @(negedge clk);
    we = 1'b1; addr = 8'd18; wdata = 8'b001;
    pv = 1'b1; src = 3'd0; dst = 5'b10000;
    @(negedge clk);
    we = 1'b0; pv = 1'b0;
    chk("R11", "old setting mask", emask, em);
    chk("R11", "old setting learn", learn, 1);
    model_write(8'd18, 8'b001);
    send("R11", 3'd0, 5'b10000, 1'b0, 1'b0, 1'b0);
    chk("R11", "new setting drop", drop, 1);
  endtask

  task automatic t_bad_src;
    send("R12", 3'd5, 5'b11111, 1'b0, 1'b0, 1'b0);
    chk("R12", "src5 drop", drop, 1);
    send("R12", 3'd7, 5'b11111, 1'b1, 1'b1, 1'b1);
    chk("R12", "src7 no learn", learn, 0);
  endtask

  initial begin
    m_tx = 4'b0000; m_rx = 4'b0000; m_ld = 4'b1111;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_forward();
    t_tx_gate();
    t_rx_block();
    t_tag();
    t_decode();
    t_same_cycle();
    t_bad_src();
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    errors++;
    checks++;
    $display("FAIL watchdog: actual=expired expected=done");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule